// File: doc/BRIEF.md
# Round-Robin Group Interrupt Target Selector

This block chooses which hardware thread receives a group interrupt. The threads sit in a grid of `NUM_CORES` cores with `NUM_THREADS` threads each. On a request cycle the block gets two inputs. The first is a match vector with one bit per thread. The second is a 2-bit ring code per thread. The block scans the grid from a rotating start point and returns the first matching thread: its core number, its thread number and its ring code. It also returns how many threads matched in total.

The start point has two parts, a core pointer and a thread pointer. Both are held in registers and shared by all requests. The thread pointer moves past the chosen thread on every successful selection. The core pointer moves only when the thread pointer wraps. Because of this rotation, repeated requests that all match do not keep landing on the same thread.

Thread `t` of core `c` sits at flat index `k = c*NUM_THREADS + t`. Its match flag is `match_vec[k]` and its ring code is `ring_vec[2k+1:2k]`.

Top module: `rr_target_sel`

## Requirements
- R1: After the synchronous active-high reset, `out_valid` is 0 and both start pointers are 0. A first request with every thread matching selects core 0, thread 0.
- R2: Results appear one clock after the request. `out_valid` is high in exactly the cycle after `req_valid` was sampled high, and the other outputs in that cycle describe that request.
- R3: Cores are scanned in the order (start_core + i) mod NUM_CORES, for offsets i from 0 to NUM_CORES-1.
- R4: Inside each core, threads are scanned in the order (start_thread + j) mod NUM_THREADS. Every core uses the same thread offset.
- R5: The first matching thread in scan order is the target. The block reports its core, its thread and the ring code `ring_vec[2k+1:2k]` of that thread, with `hit` = 1.
- R6: `match_count` equals the number of set bits in the match vector, whichever thread is chosen.
- R7: After a hit at offsets (i, j), the thread pointer becomes j + start_thread + 1, taken without a modulo. If that value is at least NUM_THREADS, the thread pointer becomes 0 and the core pointer advances to i + start_core + 1.
- R8: An advanced core pointer that is at least NUM_CORES becomes 0.
- R9: A request with no matching thread gives `hit` = 0, `match_count` = 0, and `core_id`, `thread_id` and `ring` all 0. Both pointers keep their values.
- R10: Cycles with `req_valid` low produce no `out_valid` and leave both pointers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| match_vec | input | NUM_CORES*NUM_THREADS | Per-thread match flags, flat index core*NUM_THREADS+thread |
| ring_vec | input | 2*NUM_CORES*NUM_THREADS | 2-bit ring code per thread |
| out_valid | output | 1 | Result valid, one cycle after req_valid |
| hit | output | 1 | At least one thread matched |
| core_id | output | max(1,clog2(NUM_CORES)) | Selected core |
| thread_id | output | max(1,clog2(NUM_THREADS)) | Selected thread |
| ring | output | 2 | Ring code of the selected thread |
| match_count | output | clog2(NUM_CORES*NUM_THREADS+1) | Number of matching threads |

## Verification
The hardest case to reach from the ports is a hit whose thread offset plus the start offset goes past the last thread. In that case the no-modulo rule moves the core pointer even though the chosen thread had a lower number than the start. The bench first walks the thread pointer up with several all-match requests. It then sends a vector whose only set bit sits below the current thread start, which forces this carry. A single bit in the last core is then used to push the core pointer past its top and make it wrap. Pointer values are never read directly. They are inferred from the choice made by the next all-match request.

// File: rtl/rrsel_pkg.sv
package rrsel_pkg;
    localparam int RING_W = 2;
    typedef logic [RING_W-1:0] ring_t;

    // rotated index: (base + off) reduced once into [0, modulus)
    function automatic int rot_idx(input int base, input int off, input int modulus);
        int s;
        s = base + off;
        if (s >= modulus) s = s - modulus;
        return s;
    endfunction

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rrsel_scan.sv
module rrsel_scan
    import rrsel_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int NUM_THREADS = 4,
    parameter int CW          = idx_w(NUM_CORES),
    parameter int TW          = idx_w(NUM_THREADS)
) (
    input  logic [CW-1:0]                          start_core,
    input  logic [TW-1:0]                          start_thread,
    input  logic [NUM_CORES*NUM_THREADS-1:0]        match_vec,
    input  logic [RING_W*NUM_CORES*NUM_THREADS-1:0] ring_vec,
    output logic                                   hit,
    output logic [CW-1:0]                          sel_core,
    output logic [TW-1:0]                          sel_thread,
    output logic [CW-1:0]                          sel_ioff,
    output logic [TW-1:0]                          sel_joff,
    output ring_t                                  sel_ring
);
    // priority scan over the rotated core/thread space
    always_comb begin
        int c;
        int t;
        int k;
        hit        = 1'b0;
        sel_core   = '0;
        sel_thread = '0;
        sel_ioff   = '0;
        sel_joff   = '0;
        sel_ring   = '0;
        for (int i = 0; i < NUM_CORES; i++) begin
            for (int j = 0; j < NUM_THREADS; j++) begin
                c = rot_idx(int'(start_core), i, NUM_CORES);
                t = rot_idx(int'(start_thread), j, NUM_THREADS);
                k = c * NUM_THREADS + t;
                if (!hit && match_vec[k]) begin
                    hit        = 1'b1;
                    sel_core   = CW'(c);
                    sel_thread = TW'(t);
                    sel_ioff   = CW'(i);
                    sel_joff   = TW'(j);
                    sel_ring   = ring_vec[k*RING_W +: RING_W];
                end
            end
        end
    end
endmodule

// File: rtl/rrsel_count.sv
module rrsel_count #(
    parameter int N  = 16,
    parameter int NW = $clog2(N + 1)
) (
    input  logic [N-1:0]  bits_in,
    output logic [NW-1:0] total
);
    always_comb begin
        total = '0;
        for (int k = 0; k < N; k++) begin
            total = total + NW'(bits_in[k]);
        end
    end
endmodule

// File: rtl/rrsel_ptr.sv
module rrsel_ptr
    import rrsel_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int NUM_THREADS = 4,
    parameter int CW          = idx_w(NUM_CORES),
    parameter int TW          = idx_w(NUM_THREADS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  logic [CW-1:0] sel_ioff,
    input  logic [TW-1:0] sel_joff,
    output logic [CW-1:0] start_core,
    output logic [TW-1:0] start_thread
);
    logic [CW-1:0] nxt_core;
    logic [TW-1:0] nxt_thread;

    always_comb begin
        int nt;
        int nc;
        nt         = int'(sel_joff) + int'(start_thread) + 1;
        nc         = int'(sel_ioff) + int'(start_core) + 1;
        nxt_core   = start_core;
        nxt_thread = TW'(nt);
        if (nt >= NUM_THREADS) begin
            nxt_thread = '0;
            nxt_core   = (nc >= NUM_CORES) ? '0 : CW'(nc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_core   <= '0;
            start_thread <= '0;
        end else if (upd) begin
            start_core   <= nxt_core;
            start_thread <= nxt_thread;
        end
    end

    assert_ptr_range_R8: assert property (@(posedge clk) disable iff (rst)
        (int'(start_core) < NUM_CORES) && (int'(start_thread) < NUM_THREADS));

    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !upd |=> ($stable(start_core) && $stable(start_thread)));
endmodule

// File: rtl/rr_target_sel.sv
module rr_target_sel
    import rrsel_pkg::*;
#(
    parameter int NUM_CORES   = 4,
    parameter int NUM_THREADS = 4,
    localparam int NT = NUM_CORES * NUM_THREADS,
    localparam int CW = idx_w(NUM_CORES),
    localparam int TW = idx_w(NUM_THREADS),
    localparam int NW = $clog2(NT + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [NT-1:0]        match_vec,
    input  logic [RING_W*NT-1:0] ring_vec,
    output logic                 out_valid,
    output logic                 hit,
    output logic [CW-1:0]        core_id,
    output logic [TW-1:0]        thread_id,
    output logic [RING_W-1:0]    ring,
    output logic [NW-1:0]        match_count
);
    logic [CW-1:0] start_core;
    logic [TW-1:0] start_thread;
    logic          s_hit;
    logic [CW-1:0] s_core;
    logic [TW-1:0] s_thread;
    logic [CW-1:0] s_ioff;
    logic [TW-1:0] s_joff;
    ring_t         s_ring;
    logic [NW-1:0] s_count;

    rrsel_scan #(.NUM_CORES(NUM_CORES), .NUM_THREADS(NUM_THREADS), .CW(CW), .TW(TW)) u_scan (
        .start_core  (start_core),
        .start_thread(start_thread),
        .match_vec   (match_vec),
        .ring_vec    (ring_vec),
        .hit         (s_hit),
        .sel_core    (s_core),
        .sel_thread  (s_thread),
        .sel_ioff    (s_ioff),
        .sel_joff    (s_joff),
        .sel_ring    (s_ring)
    );

    rrsel_count #(.N(NT), .NW(NW)) u_count (
        .bits_in(match_vec),
        .total  (s_count)
    );

    rrsel_ptr #(.NUM_CORES(NUM_CORES), .NUM_THREADS(NUM_THREADS), .CW(CW), .TW(TW)) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .upd         (req_valid && s_hit),
        .sel_ioff    (s_ioff),
        .sel_joff    (s_joff),
        .start_core  (start_core),
        .start_thread(start_thread)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            hit         <= 1'b0;
            core_id     <= '0;
            thread_id   <= '0;
            ring        <= '0;
            match_count <= '0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                hit         <= s_hit;
                core_id     <= s_core;
                thread_id   <= s_thread;
                ring        <= s_ring;
                match_count <= s_count;
            end
        end
    end

    assert_valid_delay_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    assert_miss_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !hit) |-> (match_count == '0));

    assert_hit_counted_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && hit) |-> (match_count != '0));
endmodule

// File: tb/rr_target_sel_bench.sv
module rr_target_sel_bench;
    localparam int C  = 4;
    localparam int T  = 4;
    localparam int N  = C * T;
    localparam int NW = $clog2(N + 1);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic [N-1:0]    match_vec = '0;
    logic [2*N-1:0]  ring_vec = '0;
    logic            out_valid;
    logic            hit;
    logic [1:0]      core_id;
    logic [1:0]      thread_id;
    logic [1:0]      ring;
    logic [NW-1:0]   match_count;

    always #4 clk = ~clk;

    rr_target_sel #(.NUM_CORES(C), .NUM_THREADS(T)) u_rr_target_sel (
        .clk(clk), .rst(rst), .req_valid(req_valid), .match_vec(match_vec),
        .ring_vec(ring_vec), .out_valid(out_valid), .hit(hit), .core_id(core_id),
        .thread_id(thread_id), .ring(ring), .match_count(match_count)
    );

    typedef struct {
        bit    e_hit;
        int    e_core;
        int    e_thr;
        int    e_ring;
        int    e_cnt;
        string tag;
    } exp_t;

    exp_t  sb[$];
    int    checks = 0;
    int    failures = 0;
    int    m_sc = 0;
    int    m_st = 0;
    bit    done = 0;
    logic [31:0] lfsr = 32'hACE1_1234;

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] step(input logic [31:0] v);
        return {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]};
    endfunction

    // reference model built from the requirements
    task automatic drive(input logic [N-1:0] m, input logic [2*N-1:0] r, input string tag);
        exp_t e;
        e.e_hit = 0; e.e_core = 0; e.e_thr = 0; e.e_ring = 0; e.e_cnt = 0; e.tag = tag;
        for (int k = 0; k < N; k++) e.e_cnt += int'(m[k]);
        for (int i = 0; i < C; i++) begin
            for (int j = 0; j < T; j++) begin
                int c = (m_sc + i) % C;
                int t = (m_st + j) % T;
                if (!e.e_hit && m[c*T+t]) begin
                    e.e_hit = 1; e.e_core = c; e.e_thr = t;
                    e.e_ring = int'(r[2*(c*T+t) +: 2]);
                    if (j + m_st + 1 >= T) begin
                        m_st = 0;
                        m_sc = (i + m_sc + 1 >= C) ? 0 : i + m_sc + 1;
                    end else begin
                        m_st = j + m_st + 1;
                    end
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b1;
        match_vec = m;
        ring_vec  = r;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // monitor: compare each result as it appears
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check("R2", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, "hit", int'(hit), int'(e.e_hit));
                check(e.tag, "core_id", int'(core_id), e.e_core);
                check(e.tag, "thread_id", int'(thread_id), e.e_thr);
                check(e.tag, "ring", int'(ring), e.e_ring);
                check(e.tag, "match_count", int'(match_count), e.e_cnt);
            end
        end
    end

    initial begin
        logic [2*N-1:0] rv;
        for (int k = 0; k < N; k++) rv[2*k +: 2] = 2'(k ^ (k >> 2));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "out_valid after reset", int'(out_valid), 0);

        drive({N{1'b1}}, rv, "R1");          // core0 thread0
        drive({N{1'b1}}, rv, "R7");          // thread start now 1
        drive(16'h0001, rv, "R4");           // lone bit below start: carry to core 1
        drive({N{1'b1}}, rv, "R7");          // core1 thread0
        drive('0, rv, "R9");                 // miss: pointers kept
        drive({N{1'b1}}, rv, "R9");          // proves pointers held
        repeat (5) @(negedge clk);
        check("R10", "out_valid while idle", int'(out_valid), 0);
        drive({N{1'b1}}, rv, "R10");         // pointers unchanged by idle cycles
        drive(16'h8000, rv, "R8");           // core3 thread3: core pointer wraps
        drive({N{1'b1}}, rv, "R8");
        drive(16'h0F00, rv, "R3");           // only core 2 matches
        drive(16'h2222, rv, "R4");           // thread 1 in every core

        for (int n = 0; n < 60; n++) begin
            logic [N-1:0] m;
            lfsr = step(lfsr); m = lfsr[15:0];
            lfsr = step(lfsr); if (n % 3 == 0) m = m & lfsr[15:0] & lfsr[31:16];
            lfsr = step(lfsr); rv = {lfsr, step(lfsr)};
            drive(m, rv, (n % 2 == 0) ? "R5" : "R6");
        end
        repeat (3) @(negedge clk);
        check("R2", "scoreboard drained", sb.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule